// File: doc/BRIEF.md
# Endpoint Polling Interval and NAK Timer

This block is a per-endpoint timer for a USB host controller. One copy sits beside each configured endpoint other than endpoint 0. It counts frame or microframe ticks that an external start-of-frame generator supplies. It reads one 8-bit interval value, whose meaning depends on the endpoint's transfer type and bus speed.

For interrupt and isochronous endpoints the block produces a one-cycle `poll_due` pulse at the endpoint's polling period. For bulk endpoints it instead measures how long the device has answered with an unbroken run of NAK handshakes, and raises `nak_timeout` once the limit is reached.

Every pin is a plain control or status signal. No data flows through the block, so there is no valid/ready handshake and no back-pressure. `tick`, `nak_seen` and `resp_ok` are single-cycle strobes. The scheduler drives them no more often than once per clock.

Top module: `ept_interval_timer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `poll_due` and `nak_timeout` are both 0.
- R2: With `xfer_type` = 3 (interrupt) and `speed` = 0 (low) or 1 (full), an interval value m from 1 to 255 gives one `poll_due` pulse every m ticks. A value of 0 behaves as 1.
- R3: With `xfer_type` = 3 and `speed` = 2 or 3 (high), the polling period is 2^(m-1) ticks. A value of 0 is taken as 1, and any value above 16 is taken as 16.
- R4: With `xfer_type` = 1 (isochronous), at any speed, the polling period is 2^(m-1) ticks, using the same clamping as R3.
- R5: After `enable` rises, or after the transfer type becomes periodic, the first tick produces a `poll_due` pulse. The pulse is high for exactly one cycle, in the cycle after the tick.
- R6: With `xfer_type` = 2 (bulk) and m from 2 to 16 (values above 16 taken as 16), the first NAK starts a count. `nak_timeout` goes high in the cycle after the 2^(m-1)-th tick that follows the NAK's cycle. It then stays high.
- R7: For a bulk endpoint with m equal to 0 or 1, `nak_timeout` never asserts, however many NAKs and ticks arrive.
- R8: A `resp_ok` strobe, or `enable` low, clears the NAK count and drops `nak_timeout` in the next cycle. `enable` low also stops `poll_due`, and the next enable starts again as in R5.
- R9: A new interval value written while a period or NAK run is under way takes effect only at the next period restart or the next NAK run. The gap in progress keeps its old length.
- R10: `poll_due` never pulses for bulk (2) or control (0) endpoints. `nak_timeout` never asserts for interrupt, isochronous or control endpoints.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Endpoint active |
| tick | input | 1 | One-cycle frame/microframe strobe |
| xfer_type | input | 2 | 0 control, 1 isochronous, 2 bulk, 3 interrupt |
| speed | input | 2 | 0 low, 1 full, 2 or 3 high |
| interval | input | 8 | Interval / NAK-limit value m |
| nak_seen | input | 1 | Strobe: the device answered NAK |
| resp_ok | input | 1 | Strobe: the device answered with anything other than NAK |
| poll_due | output | 1 | One-cycle pulse: the endpoint should be polled |
| nak_timeout | output | 1 | Level: the NAK run reached its limit |

## Verification
The polling path is measured as tick counts between pulses in several cases:
- a linear interval at full speed;
- a zero interval;
- exponent intervals at high speed, including a value above 16 that must clamp;
- isochronous endpoints at two speeds.

Together these separate the linear reading of the interval from the exponent reading, and show that clamping is applied. The NAK path is driven with runs that stop one tick short of the limit and runs that exceed it. It is also driven with limits of 0 and 1, and with runs cut by a good response or by disabling the endpoint, which separates the threshold from the hold and clear rules. Interval changes in mid-period show that a new value is applied only at a restart.

A constrained-random phase then mixes ticks, NAKs, good responses, enable drops and changes of type, speed and interval. In that phase the outputs are compared against a model every cycle.

// File: rtl/ept_pkg.sv
package ept_pkg;
  typedef enum logic [1:0] {
    XF_CTRL = 2'd0,
    XF_ISO  = 2'd1,
    XF_BULK = 2'd2,
    XF_INTR = 2'd3
  } xfer_e;

  typedef enum logic [1:0] {
    SPD_LOW  = 2'd0,
    SPD_FULL = 2'd1,
    SPD_HIGH = 2'd2,
    SPD_HI2  = 2'd3
  } speed_e;

  function automatic logic is_high_speed(input logic [1:0] spd);
    return spd[1];
  endfunction
endpackage

// File: rtl/ept_interval_decode.sv
module ept_interval_decode #(
  parameter int IVL_W   = 8,
  parameter int EXP_MAX = 16,
  parameter int CNT_W   = 16
) (
  input  logic [1:0]       xfer_type,
  input  logic [1:0]       speed,
  input  logic [IVL_W-1:0] interval,
  output logic             poll_active,
  output logic [CNT_W-1:0] poll_period,
  output logic             nak_active,
  output logic             nak_limit_en,
  output logic [CNT_W-1:0] nak_limit
);
  import ept_pkg::*;

  logic [IVL_W-1:0] exp_c;
  logic [CNT_W-1:0] pow_val;
  logic [CNT_W-1:0] lin_val;
  logic             linear;

  // Exponent value after clamping into 1..EXP_MAX
  always_comb begin
    if (interval == '0)
      exp_c = IVL_W'(1);
    else if (interval > IVL_W'(EXP_MAX))
      exp_c = IVL_W'(EXP_MAX);
    else
      exp_c = interval;
  end

  assign pow_val = CNT_W'(1) << (exp_c - IVL_W'(1));
  assign lin_val = (interval == '0) ? CNT_W'(1) : CNT_W'(interval);

  assign linear       = (xfer_type == XF_INTR) && !is_high_speed(speed);
  assign poll_active  = (xfer_type == XF_INTR) || (xfer_type == XF_ISO);
  assign poll_period  = linear ? lin_val : pow_val;
  assign nak_active   = (xfer_type == XF_BULK);
  assign nak_limit_en = nak_active && (interval >= IVL_W'(2));
  assign nak_limit    = pow_val;
endmodule

// File: rtl/ept_poll_timer.sv
module ept_poll_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  output logic             poll_due
);
  logic             started;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] per_q;
  logic             due_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started <= 1'b0;
      cnt     <= '0;
      per_q   <= CNT_W'(1);
      due_q   <= 1'b0;
    end else begin
      due_q <= 1'b0;
      if (!run) begin
        started <= 1'b0;
        cnt     <= '0;
      end else if (tick) begin
        if (!started || cnt == per_q - CNT_W'(1)) begin
          due_q   <= 1'b1;
          started <= 1'b1;
          cnt     <= '0;
          per_q   <= period;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  assign poll_due = due_q;

  // R5
  poll_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_due |-> $past(tick));

  // R8
  poll_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !poll_due);

  // R9
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> (cnt < per_q));
endmodule

// File: rtl/ept_nak_timer.sv
module ept_nak_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             nak_seen,
  input  logic             resp_ok,
  input  logic             limit_en,
  input  logic [CNT_W-1:0] limit,
  output logic             timeout
);
  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim_q;
  logic             to_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
      lim_q <= CNT_W'(1);
      to_q  <= 1'b0;
    end else if (!run || resp_ok) begin
      armed <= 1'b0;
      cnt   <= '0;
      to_q  <= 1'b0;
    end else if (!armed) begin
      if (nak_seen && limit_en) begin
        armed <= 1'b1;
        cnt   <= '0;
        lim_q <= limit;
      end
    end else if (tick && !to_q) begin
      cnt <= cnt + CNT_W'(1);
      if (cnt + CNT_W'(1) == lim_q)
        to_q <= 1'b1;
    end
  end

  assign timeout = to_q;

  // R8
  nak_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_ok || !run) |=> !timeout);

  // R6
  nak_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && run && !resp_ok) |=> timeout);

  // R7
  nak_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !timeout);
endmodule

// File: rtl/ept_interval_timer.sv
module ept_interval_timer #(
  parameter int IVL_W   = 8,
  parameter int EXP_MAX = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tick,
  input  logic [1:0]       xfer_type,
  input  logic [1:0]       speed,
  input  logic [IVL_W-1:0] interval,
  input  logic             nak_seen,
  input  logic             resp_ok,
  output logic             poll_due,
  output logic             nak_timeout
);
  localparam int CNT_W = (IVL_W > EXP_MAX) ? IVL_W : EXP_MAX;

  logic             poll_active;
  logic [CNT_W-1:0] poll_period;
  logic             nak_active;
  logic             nak_limit_en;
  logic [CNT_W-1:0] nak_limit;

  ept_interval_decode #(.IVL_W(IVL_W), .EXP_MAX(EXP_MAX), .CNT_W(CNT_W)) u_dec (
    .xfer_type    (xfer_type),
    .speed        (speed),
    .interval     (interval),
    .poll_active  (poll_active),
    .poll_period  (poll_period),
    .nak_active   (nak_active),
    .nak_limit_en (nak_limit_en),
    .nak_limit    (nak_limit)
  );

  ept_poll_timer #(.CNT_W(CNT_W)) u_poll (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (enable && poll_active),
    .tick     (tick),
    .period   (poll_period),
    .poll_due (poll_due)
  );

  ept_nak_timer #(.CNT_W(CNT_W)) u_nak (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (enable && nak_active),
    .tick     (tick),
    .nak_seen (nak_seen),
    .resp_ok  (resp_ok),
    .limit_en (nak_limit_en),
    .limit    (nak_limit),
    .timeout  (nak_timeout)
  );

  // R10
  modes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(poll_due && nak_timeout));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!poll_due && !nak_timeout));
endmodule

// File: tb/sim_ept_interval_timer.sv
module sim_ept_interval_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] xfer_type = 2'd0;
  logic [1:0] speed = 2'd0;
  logic [7:0] interval = 8'd0;
  logic       nak_seen = 1'b0;
  logic       resp_ok = 1'b0;
  logic       poll_due;
  logic       nak_timeout;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ept_interval_timer u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
    .xfer_type(xfer_type), .speed(speed), .interval(interval),
    .nak_seen(nak_seen), .resp_ok(resp_ok),
    .poll_due(poll_due), .nak_timeout(nak_timeout)
  );

  // ---------------- reference functions from the requirements
  function automatic int clamp_exp(input int m);
    if (m == 0) return 1;
    if (m > 16) return 16;
    return m;
  endfunction

  function automatic int pow2m1(input int m);
    int p = 1;
    for (int k = 1; k < clamp_exp(m); k++) p = p * 2;
    return p;
  endfunction

  function automatic int ref_period(input int t, input int s, input int m);
    if (t == 3 && s < 2) return (m == 0) ? 1 : m;
    return pow2m1(m);
  endfunction

  function automatic string mode_tag(input int t, input int s, input int m);
    if (t == 3) return (s < 2) ? "R2" : "R3";
    if (t == 1) return "R4";
    if (t == 2) return (m < 2) ? "R7" : "R6";
    return "R10";
  endfunction

  // ---------------- cycle model
  bit m_started, m_poll, m_armed, m_to;
  int m_cnt, m_per, m_ncnt, m_lim;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_started <= 0; m_poll <= 0; m_cnt <= 0; m_per <= 1;
      m_armed <= 0; m_to <= 0; m_ncnt <= 0; m_lim <= 1;
    end else begin
      m_poll <= 0;
      if (!(enable && (xfer_type == 1 || xfer_type == 3))) begin
        m_started <= 0; m_cnt <= 0;
      end else if (tick) begin
        if (!m_started || m_cnt + 1 == m_per) begin
          m_poll <= 1; m_started <= 1; m_cnt <= 0;
          m_per <= ref_period(xfer_type, speed, interval);
        end else m_cnt <= m_cnt + 1;
      end
      if (!(enable && xfer_type == 2) || resp_ok) begin
        m_armed <= 0; m_ncnt <= 0; m_to <= 0;
      end else if (!m_armed) begin
        if (nak_seen && interval >= 2) begin
          m_armed <= 1; m_ncnt <= 0; m_lim <= pow2m1(interval);
        end
      end else if (tick && !m_to) begin
        m_ncnt <= m_ncnt + 1;
        if (m_ncnt + 1 == m_lim) m_to <= 1;
      end
    end
  end

  // Continuous comparison against the model, away from the clock edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (poll_due !== m_poll || nak_timeout !== m_to) begin
        errors++;
        $display("FAIL %s model: poll_due=%0b nak_timeout=%0b expected %0b %0b",
                 mode_tag(xfer_type, speed, interval), poll_due, nak_timeout, m_poll, m_to);
      end
    end
  end

  // ---------------- helpers
  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic pulse_nak();
    @(negedge clk) nak_seen = 1'b1;
    @(negedge clk) nak_seen = 1'b0;
  endtask

  task automatic pulse_ok();
    @(negedge clk) resp_ok = 1'b1;
    @(negedge clk) resp_ok = 1'b0;
  endtask

  task automatic set_cfg(input bit en, input int t, input int s, input int m);
    @(negedge clk);
    enable = en; xfer_type = 2'(t); speed = 2'(s); interval = 8'(m);
  endtask

  task automatic gap(output int n);
    n = 0;
    do begin do_tick(); n++; end while (!poll_due && n < 70000);
  endtask

  task automatic restart(input int t, input int s, input int m, input string tag);
    set_cfg(0, t, s, m);
    set_cfg(1, t, s, m);
    do_tick();
    chk(tag, poll_due, 1);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    void'($urandom(32'd20251));
    repeat (3) @(negedge clk);
    chk("R1 poll_due in reset", poll_due, 0);
    chk("R1 nak_timeout in reset", nak_timeout, 0);
    @(negedge clk) rst_n = 1'b1;
    chk("R1 poll_due after reset", poll_due, 0);
    chk("R1 nak_timeout after reset", nak_timeout, 0);

    // R5 first pulse and pulse width
    set_cfg(1, 3, 1, 3);
    do_tick();
    chk("R5 first tick pulse", poll_due, 1);
    @(negedge clk);
    chk("R5 one-cycle pulse", poll_due, 0);
    // R2 linear period, R9 deferred change
    gap(n); chk("R2 FS interrupt m=3 gap", n, 3);
    do_tick();
    @(negedge clk) interval = 8'd5;
    gap(n); chk("R9 gap after mid-period change", n, 2);
    gap(n); chk("R2 FS interrupt m=5 gap", n, 5);
    @(negedge clk) interval = 8'd0;
    gap(n); chk("R9 old gap kept", n, 5);
    gap(n); chk("R2 m=0 behaves as 1", n, 1);
    restart(3, 0, 7, "R5 restart LS");
    gap(n); chk("R2 LS interrupt m=7 gap", n, 7);

    // R3 high-speed exponent and clamping
    restart(3, 2, 4, "R5 restart HS");
    gap(n); chk("R3 HS interrupt m=4 gap", n, 8);
    restart(3, 3, 0, "R5 restart HS m=0");
    gap(n); chk("R3 HS interrupt m=0 gap", n, 1);
    restart(3, 2, 20, "R5 restart HS m=20");
    gap(n); chk("R3 HS interrupt m=20 clamps", n, 32768);

    // R4 isochronous
    restart(1, 1, 1, "R5 restart iso");
    gap(n); chk("R4 iso FS m=1 gap", n, 1);
    restart(1, 2, 3, "R5 restart iso HS");
    gap(n); chk("R4 iso HS m=3 gap", n, 4);

    // R10 no NAK timeout in periodic modes
    pulse_nak();
    repeat (10) do_tick();
    chk("R10 no nak_timeout for iso", nak_timeout, 0);

    // R6 bulk limit threshold and hold
    set_cfg(1, 2, 2, 3);
    pulse_nak();
    repeat (3) do_tick();
    chk("R6 one tick short of limit", nak_timeout, 0);
    do_tick();
    chk("R6 timeout at limit 4", nak_timeout, 1);
    repeat (3) do_tick();
    pulse_nak();
    chk("R6 timeout holds", nak_timeout, 1);
    chk("R10 no poll for bulk", poll_due, 0);
    // R8 clear by good response
    @(negedge clk) resp_ok = 1'b1;
    @(negedge clk) resp_ok = 1'b0;
    chk("R8 resp_ok clears", nak_timeout, 0);
    // R9 new limit only on next run
    pulse_nak();
    @(negedge clk) interval = 8'd2;
    repeat (3) do_tick();
    chk("R9 old limit kept", nak_timeout, 0);
    do_tick();
    chk("R9 old limit reached", nak_timeout, 1);
    pulse_ok();
    pulse_nak();
    repeat (2) do_tick();
    chk("R6 new limit 2 reached", nak_timeout, 1);
    // R8 clear by enable low
    @(negedge clk) enable = 1'b0;
    @(negedge clk);
    chk("R8 enable low clears", nak_timeout, 0);
    @(negedge clk) enable = 1'b1;

    // R7 disabled limits
    set_cfg(1, 2, 1, 1);
    pulse_nak();
    repeat (40) do_tick();
    chk("R7 m=1 never times out", nak_timeout, 0);
    set_cfg(1, 2, 2, 0);
    pulse_nak();
    repeat (40) do_tick();
    chk("R7 m=0 never times out", nak_timeout, 0);

    // R10 control endpoint
    set_cfg(1, 0, 1, 1);
    pulse_nak();
    do_tick();
    chk("R10 no poll for control", poll_due, 0);
    chk("R10 no nak_timeout for control", nak_timeout, 0);

    // constrained random phase, compared against the model each cycle
    for (int i = 0; i < 30000; i++) begin
      @(negedge clk);
      tick     = ($urandom % 3) == 0;
      nak_seen = ($urandom % 5) == 0;
      resp_ok  = ($urandom % 29) == 0;
      if (($urandom % 400) == 0) begin
        xfer_type = 2'($urandom % 4);
        speed     = 2'($urandom % 4);
        interval  = (($urandom % 10) == 0) ? 8'($urandom) : 8'($urandom % 7);
      end
      if (($urandom % 250) == 0) enable = ~enable;
      else if (!enable && ($urandom % 20) == 0) enable = 1'b1;
    end
    @(negedge clk);
    tick = 0; nak_seen = 0; resp_ok = 0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule